// File: doc/BRIEF.md
# Multiple-Bus Memory Request Arbiter

This block decides, every clock cycle, which processor requests reach memory when a group of processors shares a small pool of buses leading to a set of memory modules. Each processor raises a request that names one target module. Arbitration happens in two levels. First, every module independently selects at most one of the processors that want it, in round-robin order. Second, the module winners compete for whichever buses are currently idle. Any idle bus can carry a transfer to any module.

A granted processor is told which bus it received through a one-cycle grant pulse. It then keeps that bus, and the target module, until it raises its done line. The block also reports how many requests it accepted in the cycle. It is placed between the processors' request logic and the bus multiplexers, which take the grant and bus index to steer their data paths. The block does not handle data or memory timing.

Top module: `mbus_arbiter`

## Requirements
- R1: In any cycle, at most one processor is granted for a given memory module.
- R2: Among the eligible requesters of one module, the search starts at processor 0 after reset. After a winner of that module obtains a bus, the search starts at the processor just above that winner, wrapping around.
- R3: `accept_cnt` equals the number of modules that have an eligible requester, capped at the number of idle buses, and never exceeds the bus count.
- R4: Module winners are served in service order, and each one takes the lowest-numbered idle bus not yet taken in that cycle. A bus that is held is never granted.
- R5: Service order starts at module 0 after reset. The start advances by one module, wrapping, after each cycle in which at least one module winner found no idle bus.
- R6: A processor holds its bus and module from its grant until the cycle in which it raises `done`. The freed bus and module can be granted from the next cycle on.
- R7: A request to a module that is in an ongoing transaction is not granted.
- R8: `grant[p]` is a one-cycle pulse that comes only with `req_valid[p]` and a matching target. `grant_bus` carries the assigned bus index, 0 for ungranted processors, in field `[p*BUS_W +: BUS_W]`. The target is read from `req_mod[p*MOD_W +: MOD_W]`. Requests from a processor that already holds a bus are ignored.
- R9: `done` from a processor that holds no bus has no effect.
- R10: After reset, all buses and modules are free, and `grant` and `accept_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | N_PROC | Per-processor request line |
| req_mod | input | N_PROC*MOD_W | Per-processor target module index |
| done | input | N_PROC | Per-processor end-of-transaction strobe |
| grant | output | N_PROC | Per-processor grant pulse |
| grant_bus | output | N_PROC*BUS_W | Per-processor assigned bus index |
| accept_cnt | output | CNT_W | Number of grants in this cycle |

## Verification
The grant, bus index and accept count are combinational responses to the current request and the registered ownership state. The bench therefore drives inputs just after a rising edge and compares all three outputs at the following falling edge, in the same cycle. A `done` or a grant changes ownership only at the next rising edge, so its effect is checked one cycle later. The reference model applies releases and new grants at the same point in its loop. Directed sequences fix the exact cycle in which each round-robin pointer and the service-order start should move. A randomized phase with multi-cycle holds is then compared cycle by cycle.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mbarb_rr.sv
module mbarb_rr #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          win_vld,
  output logic [PW-1:0] win_idx
);
  logic [PW-1:0] ptr_q, ptr_d;
  int idx;

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    idx     = 0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (!win_vld && req[idx]) begin
        win_vld = 1'b1;
        win_idx = PW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (int'(win_idx) == N - 1) ptr_d = '0;
      else                        ptr_d = win_idx + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/mbarb_alloc.sv
module mbarb_alloc #(
  parameter int M  = 4,
  parameter int B  = 2,
  parameter int MW = 2,
  parameter int BW = 1,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [M-1:0]  win_vld,
  input  logic [B-1:0]  bus_free,
  output logic [M-1:0]  mod_ok,
  output logic [M*BW-1:0] mod_bus,
  output logic [CW-1:0] cnt
);
  logic [MW-1:0] start_q, start_d;
  logic [B-1:0]  taken;
  logic          denied;
  logic          found;
  int            m;

  always_comb begin
    mod_ok  = '0;
    mod_bus = '0;
    cnt     = '0;
    taken   = '0;
    denied  = 1'b0;
    found   = 1'b0;
    m       = 0;
    for (int k = 0; k < M; k++) begin
      m = int'(start_q) + k;
      if (m >= M) m = m - M;
      if (win_vld[m]) begin
        found = 1'b0;
        for (int b = 0; b < B; b++) begin
          if (!found && bus_free[b] && !taken[b]) begin
            found = 1'b1;
            taken[b] = 1'b1;
            mod_bus[m*BW +: BW] = BW'(b);
          end
        end
        if (found) begin
          mod_ok[m] = 1'b1;
          cnt = cnt + CW'(1);
        end else begin
          denied = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (int'(start_q) == M - 1) start_d = '0;
    else                        start_d = start_q + MW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      start_q <= '0;
    else if (denied) start_q <= start_d;
  end
endmodule

// File: rtl/mbarb_track.sv
module mbarb_track #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int B  = 2,
  parameter int MW = 2,
  parameter int BW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    gnt,
  input  logic [N*BW-1:0] gnt_bus,
  input  logic [N*MW-1:0] gnt_mod,
  input  logic [N-1:0]    done,
  output logic [B-1:0]    bus_free,
  output logic [M-1:0]    mod_busy,
  output logic [N-1:0]    proc_busy
);
  logic [N-1:0]  pbusy_q, pbusy_d;
  logic [B-1:0]  bhold_q, bhold_d;
  logic [M-1:0]  mbusy_q, mbusy_d;
  logic [BW-1:0] pbus_q [N];
  logic [BW-1:0] pbus_d [N];
  logic [MW-1:0] pmod_q [N];
  logic [MW-1:0] pmod_d [N];
  logic          upd;

  always_comb begin
    pbusy_d = pbusy_q;
    bhold_d = bhold_q;
    mbusy_d = mbusy_q;
    pbus_d  = pbus_q;
    pmod_d  = pmod_q;
    for (int p = 0; p < N; p++) begin
      if (done[p] && pbusy_q[p]) begin
        pbusy_d[p]         = 1'b0;
        bhold_d[pbus_q[p]] = 1'b0;
        mbusy_d[pmod_q[p]] = 1'b0;
      end
    end
    for (int p = 0; p < N; p++) begin
      if (gnt[p]) begin
        pbusy_d[p] = 1'b1;
        pbus_d[p]  = gnt_bus[p*BW +: BW];
        pmod_d[p]  = gnt_mod[p*MW +: MW];
        bhold_d[gnt_bus[p*BW +: BW]] = 1'b1;
        mbusy_d[gnt_mod[p*MW +: MW]] = 1'b1;
      end
    end
  end

  assign upd = (|gnt) || (|(done & pbusy_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbusy_q <= '0;
      bhold_q <= '0;
      mbusy_q <= '0;
      for (int p = 0; p < N; p++) begin
        pbus_q[p] <= '0;
        pmod_q[p] <= '0;
      end
    end else if (upd) begin
      pbusy_q <= pbusy_d;
      bhold_q <= bhold_d;
      mbusy_q <= mbusy_d;
      pbus_q  <= pbus_d;
      pmod_q  <= pmod_d;
    end
  end

  assign bus_free  = ~bhold_q;
  assign mod_busy  = mbusy_q;
  assign proc_busy = pbusy_q;
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
  import mbarb_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_MOD  = 4,
  parameter int N_BUS  = 2,
  localparam int PROC_W = idx_w(N_PROC),
  localparam int MOD_W  = idx_w(N_MOD),
  localparam int BUS_W  = idx_w(N_BUS),
  localparam int CNT_W  = $clog2(N_BUS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PROC-1:0]       req_valid,
  input  logic [N_PROC*MOD_W-1:0] req_mod,
  input  logic [N_PROC-1:0]       done,
  output logic [N_PROC-1:0]       grant,
  output logic [N_PROC*BUS_W-1:0] grant_bus,
  output logic [CNT_W-1:0]        accept_cnt
);
  logic [N_PROC-1:0]      elig [N_MOD];
  logic [N_MOD-1:0]       win_vld;
  logic [PROC_W-1:0]      win_idx [N_MOD];
  logic [N_MOD-1:0]       mod_ok;
  logic [N_MOD*BUS_W-1:0] mod_bus;
  logic [N_BUS-1:0]       bus_free;
  logic [N_MOD-1:0]       mod_busy;
  logic [N_PROC-1:0]      proc_busy;

  always_comb begin
    for (int m = 0; m < N_MOD; m++) begin
      for (int p = 0; p < N_PROC; p++) begin
        elig[m][p] = req_valid[p] && !proc_busy[p] && !mod_busy[m] &&
                     (req_mod[p*MOD_W +: MOD_W] == MOD_W'(m));
      end
    end
  end

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    mbarb_rr #(.N(N_PROC), .PW(PROC_W)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig[g]),
      .adv     (mod_ok[g]),
      .win_vld (win_vld[g]),
      .win_idx (win_idx[g])
    );
  end

  mbarb_alloc #(
    .M(N_MOD), .B(N_BUS), .MW(MOD_W), .BW(BUS_W), .CW(CNT_W)
  ) u_alloc (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_vld  (win_vld),
    .bus_free (bus_free),
    .mod_ok   (mod_ok),
    .mod_bus  (mod_bus),
    .cnt      (accept_cnt)
  );

  always_comb begin
    grant     = '0;
    grant_bus = '0;
    for (int p = 0; p < N_PROC; p++) begin
      for (int m = 0; m < N_MOD; m++) begin
        if (mod_ok[m] && win_idx[m] == PROC_W'(p)) begin
          grant[p] = 1'b1;
          grant_bus[p*BUS_W +: BUS_W] = mod_bus[m*BUS_W +: BUS_W];
        end
      end
    end
  end

  mbarb_track #(
    .N(N_PROC), .M(N_MOD), .B(N_BUS), .MW(MOD_W), .BW(BUS_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (grant),
    .gnt_bus   (grant_bus),
    .gnt_mod   (req_mod),
    .done      (done),
    .bus_free  (bus_free),
    .mod_busy  (mod_busy),
    .proc_busy (proc_busy)
  );
endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk
  import mbarb_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_MOD  = 4,
  parameter int N_BUS  = 2,
  localparam int PROC_W = idx_w(N_PROC),
  localparam int MOD_W  = idx_w(N_MOD),
  localparam int BUS_W  = idx_w(N_BUS),
  localparam int CNT_W  = $clog2(N_BUS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PROC-1:0]       req_valid,
  input logic [N_PROC*MOD_W-1:0] req_mod,
  input logic [N_PROC-1:0]       done,
  input logic [N_PROC-1:0]       grant,
  input logic [N_PROC*BUS_W-1:0] grant_bus,
  input logic [CNT_W-1:0]        accept_cnt
);
  logic [N_BUS-1:0]  held_q;
  logic [PROC_W-1:0] own_q [N_BUS];
  logic              same_mod, same_bus, regrant;

  // Shadow of bus ownership built from port activity only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      for (int b = 0; b < N_BUS; b++) own_q[b] <= '0;
    end else begin
      for (int b = 0; b < N_BUS; b++)
        if (held_q[b] && done[own_q[b]]) held_q[b] <= 1'b0;
      for (int p = 0; p < N_PROC; p++)
        if (grant[p]) begin
          held_q[grant_bus[p*BUS_W +: BUS_W]] <= 1'b1;
          own_q[grant_bus[p*BUS_W +: BUS_W]]  <= PROC_W'(p);
        end
    end
  end

  always_comb begin
    same_mod = 1'b0;
    same_bus = 1'b0;
    regrant  = 1'b0;
    for (int p = 0; p < N_PROC; p++) begin
      if (grant[p] && held_q[grant_bus[p*BUS_W +: BUS_W]]) regrant = 1'b1;
      for (int q = p + 1; q < N_PROC; q++) begin
        if (grant[p] && grant[q]) begin
          if (req_mod[p*MOD_W +: MOD_W] == req_mod[q*MOD_W +: MOD_W]) same_mod = 1'b1;
          if (grant_bus[p*BUS_W +: BUS_W] == grant_bus[q*BUS_W +: BUS_W]) same_bus = 1'b1;
        end
      end
    end
  end

  a_r1_one_per_module: assert property (@(posedge clk) disable iff (!rst_n) !same_mod);
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(accept_cnt) <= N_BUS) && (int'(accept_cnt) == $countones(grant)));
  a_r4_distinct_bus: assert property (@(posedge clk) disable iff (!rst_n) !same_bus);
  a_r4_no_regrant: assert property (@(posedge clk) disable iff (!rst_n) !regrant);

  for (genvar g = 0; g < N_PROC; g++) begin : g_p
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |=> !grant[g]);
    a_r8_req_backed: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> req_valid[g]);
  end
endmodule

bind mbus_arbiter mbus_arbiter_chk #(
  .N_PROC(N_PROC), .N_MOD(N_MOD), .N_BUS(N_BUS)
) u_chk (.*);

// File: tb/mbus_arbiter_test.sv
module mbus_arbiter_test;
  localparam int NP = 4, NM = 4, NB = 2, MW = 2, BW = 1, CW = 2;

  logic clk, rst_n;
  logic [NP-1:0]    req_valid, done, grant;
  logic [NP*MW-1:0] req_mod;
  logic [NP*BW-1:0] grant_bus;
  logic [CW-1:0]    accept_cnt;

  mbus_arbiter #(.N_PROC(NP), .N_MOD(NM), .N_BUS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mod(req_mod),
    .done(done), .grant(grant), .grant_bus(grant_bus), .accept_cnt(accept_cnt));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  // reference state
  bit m_pbusy[NP]; int m_pbus[NP]; int m_pmod[NP];
  bit m_bhold[NB]; bit m_mbusy[NM]; int m_ptr[NM]; int m_start;
  bit e_g[NP]; int e_b[NP]; int e_cnt;
  // agents
  int a_st[NP]; int a_tmr[NP]; int a_mod[NP];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pack_g();
    int v = 0;
    for (int p = 0; p < NP; p++) if (e_g[p]) v |= (1 << p);
    return v;
  endfunction

  function automatic int pack_b();
    int v = 0;
    for (int p = 0; p < NP; p++) v |= (e_b[p] << (p*BW));
    return v;
  endfunction

  task automatic model_step();
    bit wv[NM]; int w[NM]; bit taken[NB]; bit denied; bit found; int m; int p;
    e_cnt = 0; denied = 0;
    for (int i = 0; i < NP; i++) begin e_g[i] = 0; e_b[i] = 0; end
    for (int b = 0; b < NB; b++) taken[b] = 0;
    for (int mm = 0; mm < NM; mm++) begin
      wv[mm] = 0; w[mm] = 0;
      for (int i = 0; i < NP; i++) begin
        p = (m_ptr[mm] + i) % NP;
        if (!wv[mm] && req_valid[p] && !m_pbusy[p] && !m_mbusy[mm] &&
            int'(req_mod[p*MW +: MW]) == mm) begin
          wv[mm] = 1; w[mm] = p;
        end
      end
    end
    for (int k = 0; k < NM; k++) begin
      m = (m_start + k) % NM;
      if (wv[m]) begin
        found = 0;
        for (int b = 0; b < NB; b++)
          if (!found && !m_bhold[b] && !taken[b]) begin
            found = 1; taken[b] = 1; e_g[w[m]] = 1; e_b[w[m]] = b;
          end
        if (found) begin e_cnt++; m_ptr[m] = (w[m] + 1) % NP; end
        else denied = 1;
      end
    end
    check("model grant (R1 R2 R5 R7 R8)", int'(grant), pack_g());
    check("model grant_bus (R4)", int'(grant_bus), pack_b());
    check("model accept_cnt (R3)", int'(accept_cnt), e_cnt);
    for (int i = 0; i < NP; i++)
      if (done[i] && m_pbusy[i]) begin
        m_pbusy[i] = 0; m_bhold[m_pbus[i]] = 0; m_mbusy[m_pmod[i]] = 0;
      end
    for (int i = 0; i < NP; i++)
      if (e_g[i]) begin
        m_pbusy[i] = 1; m_pbus[i] = e_b[i]; m_pmod[i] = int'(req_mod[i*MW +: MW]);
        m_bhold[e_b[i]] = 1; m_mbusy[m_pmod[i]] = 1;
      end
    if (denied) m_start = (m_start + 1) % NM;
  endtask

  // one directed cycle: rv, packed mods, dn; expected grant, bus, count
  task automatic step(input int rv, input int mods, input int dn,
                      input int xg, input int xb, input int xc, input string tag);
    @(posedge clk); #1;
    req_valid = NP'(rv); req_mod = (NP*MW)'(mods); done = NP'(dn);
    @(negedge clk);
    check({tag, " grant"}, int'(grant), xg);
    check({tag, " grant_bus"}, int'(grant_bus), xb);
    check({tag, " accept_cnt"}, int'(accept_cnt), xc);
    model_step();
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = '0; req_mod = '0; done = '0;
    for (int i = 0; i < NP; i++) begin
      m_pbusy[i] = 0; m_pbus[i] = 0; m_pmod[i] = 0; a_st[i] = 0; a_tmr[i] = 0; a_mod[i] = 0;
    end
    for (int b = 0; b < NB; b++) m_bhold[b] = 0;
    for (int m = 0; m < NM; m++) begin m_mbusy[m] = 0; m_ptr[m] = 0; end
    m_start = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 reset grant", int'(grant), 0);
    check("R10 reset accept_cnt", int'(accept_cnt), 0);

    // mods packed as {p3,p2,p1,p0}, 2 bits each
    step(4'b1111, 8'b10_10_10_10, 0, 4'b0001, 0, 1, "R1 conflict on module 2");
    step(4'b1110, 8'b10_10_10_10, 0, 0, 0, 0, "R7 module busy");
    step(4'b1110, 8'b10_10_10_10, 4'b0001, 0, 0, 0, "R6 freed only after edge");
    step(4'b1110, 8'b10_10_10_10, 0, 4'b0010, 0, 1, "R2 round robin next");
    step(4'b1101, 8'b01_00_00_11, 4'b1000, 4'b0100, 4'b0100, 1, "R3 capped by free buses");
    step(4'b1001, 8'b01_00_00_11, 0, 0, 0, 0, "R9 stray done ignored");
    step(4'b1001, 8'b01_00_00_11, 4'b0110, 0, 0, 0, "R6 held buses");
    step(4'b1001, 8'b01_00_00_11, 0, 4'b1001, 4'b1000, 2, "R5 rotated service order R4");
    step(0, 0, 4'b1001, 0, 0, 0, "R6 release");
    step(4'b0001, 8'b00_00_00_01, 0, 4'b0001, 0, 1, "R8 grant after release");
    step(4'b0001, 8'b00_00_00_01, 0, 0, 0, 0, "R8 holder request ignored");
    step(0, 0, 4'b0001, 0, 0, 0, "R6 release p0");

    // randomized agents, compared with the model every cycle
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(posedge clk); #1;
      for (int p = 0; p < NP; p++) begin
        req_valid[p] = (a_st[p] == 1);
        req_mod[p*MW +: MW] = MW'(a_mod[p]);
        done[p] = (a_st[p] == 2 && a_tmr[p] == 0);
      end
      @(negedge clk);
      model_step();
      for (int p = 0; p < NP; p++) begin
        case (a_st[p])
          0: if ($urandom % 2 == 0) begin a_st[p] = 1; a_mod[p] = int'($urandom % NM); end
          1: if (e_g[p]) begin a_st[p] = 2; a_tmr[p] = int'($urandom % 4); end
          default: if (a_tmr[p] == 0) a_st[p] = 0; else a_tmr[p]--;
        endcase
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule